// File: doc/BRIEF.md
# Out-of-Order Record Fetch Engine

The engine reads a block of memory that is cut into equal-sized records. It hands the records to a consumer in whatever order they can be delivered. A request gives three fields: the address of the first record, the size of one record in words, and how many records to fetch. An availability map marks which memory words can be read now, as a cache-hit hint would. The engine uses it to send ready records ahead of slow ones. The words inside any one record still come out back to back, in rising address order. A consumer whose items must keep their relative order can therefore rely on the record as the unit of ordering.

Each output beat carries the data word, the record index, the word index inside the record and a last-word flag. The stream uses a valid/ready handshake. The engine drives a synchronous read port with one cycle of latency. It does not read a word until the map reports that word available, so a slow word simply delays its own record. The engine takes one request at a time and pulses a done flag once every record has been sent.

Top module: `rec_fetch_engine`

## Requirements
- R1: After reset, reqReady is 1, and outValid, done and memRdEn are all 0.
- R2: A request is accepted only on a clock edge where reqReady and reqValid are both 1. reqReady stays 0 from the edge after acceptance until the engine is idle again. Request fields presented while busy have no effect on the output.
- R3: When a record is chosen, the engine picks the lowest-index unsent record whose first word is marked available in availMap.
- R4: If no unsent record has its first word available, the engine picks the lowest-index unsent record and waits on it.
- R5: Word w of record r is read from address (reqBase + r*reqSize + w) modulo 2^ADDR_W. The words of one record are sent consecutively, w = 0, 1, ..., reqSize-1, and no other record's beats come between them.
- R6: Each beat's outRec gives the record index and outWord gives the word index, starting at 0. outLast is 1 exactly on word reqSize-1. After the last beat of a record is accepted, outValid is 0 in the next cycle.
- R7: While outValid is 1 and outReady is 0, the next cycle keeps outValid at 1 and outData, outRec, outWord and outLast unchanged.
- R8: memRdEn is raised only when availMap has the bit at memAddr set. While that bit is 0 the engine waits on that word.
- R9: done is a one-cycle pulse that comes after every record has been sent exactly once. During the pulse outValid and reqReady are 0, and the engine is idle in the following cycle.
- R10: A request with a record count of 0 or a record size of 0 sends no beats and raises done.
- R11: A record count above MAX_REC is treated as MAX_REC.
- R12: outData equals the word that memRdData returned one cycle after the read of that word's address was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle, request can be taken |
| reqBase | input | ADDR_W | Address of the first word of record 0 |
| reqSize | input | SIZE_W | Words per record |
| reqCount | input | CNT_W | Number of records |
| availMap | input | 2^ADDR_W | One availability bit per memory word |
| memAddr | output | ADDR_W | Read address |
| memRdEn | output | 1 | Read strobe; data returns next cycle |
| memRdData | input | DATA_W | Read data |
| outValid | output | 1 | Beat present |
| outReady | input | 1 | Consumer accepts beat |
| outData | output | DATA_W | Word read from memory |
| outRec | output | REC_W | Record index of the beat |
| outWord | output | SIZE_W | Word index inside the record |
| outLast | output | 1 | Last word of the record |
| done | output | 1 | Request finished pulse |

## Verification
The stimulus covers several situations: an unavailable first record that later records must overtake, a region where most first words are missing so the engine falls back to waiting, a record that wraps past the top of the address space, counts of zero and above the limit, and a record size of zero. An engine that picked records in index order would show the wrong outRec sequence. One that switched records while waiting would break contiguity. One that mishandled wrap would return the wrong data. The consumer's ready input drops in a regular pattern, so an engine that let the beat change while stalled would be caught. Request fields are changed while the engine is busy, so an engine that latched them late would send beats for the wrong region.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_READ,
    ST_CAPT,
    ST_SEND,
    ST_FIN
  } rfeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic startRec;
    logic captWord;
    logic nextWord;
    logic closeRec;
  } rfeStrobe_t;

endpackage

// File: rtl/rfe_picker.sv
module rfe_picker #(
  parameter int ADDR_W  = 6,
  parameter int SIZE_W  = 4,
  parameter int MAX_REC = 16,
  parameter int REC_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic [SIZE_W-1:0]       recSize,
  input  logic [CNT_W-1:0]        recCount,
  input  logic [MAX_REC-1:0]      doneMap,
  input  logic [(1<<ADDR_W)-1:0]  availMap,
  output logic                    pickAny,
  output logic [REC_W-1:0]        pickRec,
  output logic [ADDR_W-1:0]       pickAddr
);

  logic [ADDR_W-1:0]  firstAddr [MAX_REC];
  logic [MAX_REC-1:0] pending;
  logic [MAX_REC-1:0] hitNow;
  logic [REC_W-1:0]   hitIdx;
  logic [REC_W-1:0]   pendIdx;

  generate
    for (genvar i = 0; i < MAX_REC; i++) begin : g_rec
      assign firstAddr[i] = base + ADDR_W'(ADDR_W'(i) * ADDR_W'(recSize));
      assign pending[i]   = !doneMap[i] && (recSize != '0) && (CNT_W'(i) < recCount);
      assign hitNow[i]    = pending[i] && availMap[firstAddr[i]];
    end
  endgenerate

  // lowest set index of each vector
  always_comb begin
    hitIdx  = '0;
    pendIdx = '0;
    for (int k = MAX_REC - 1; k >= 0; k--) begin
      if (hitNow[k])  hitIdx  = REC_W'(k);
      if (pending[k]) pendIdx = REC_W'(k);
    end
  end

  assign pickAny  = |pending;
  assign pickRec  = (|hitNow) ? hitIdx : pendIdx;
  assign pickAddr = firstAddr[pickRec];

endmodule

// File: rtl/rfe_datapath.sv
module rfe_datapath
  import rfe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int SIZE_W  = 4,
  parameter int MAX_REC = 16,
  parameter int REC_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rfeStrobe_t             stb,
  input  logic [ADDR_W-1:0]      reqBase,
  input  logic [SIZE_W-1:0]      reqSize,
  input  logic [CNT_W-1:0]       reqCount,
  input  logic [(1<<ADDR_W)-1:0] availMap,
  input  logic [DATA_W-1:0]      memRdData,
  output logic                   pickAny,
  output logic                   wordAvail,
  output logic                   lastWord,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      outData,
  output logic [REC_W-1:0]       outRec,
  output logic [SIZE_W-1:0]      outWord
);

  logic [ADDR_W-1:0]  baseR;
  logic [SIZE_W-1:0]  sizeR;
  logic [CNT_W-1:0]   countR;
  logic [MAX_REC-1:0] doneMap;
  logic [REC_W-1:0]   curRec;
  logic [SIZE_W-1:0]  wordIdx;
  logic [ADDR_W-1:0]  curAddr;
  logic [DATA_W-1:0]  dataR;
  logic [REC_W-1:0]   pickRec;
  logic [ADDR_W-1:0]  pickAddr;

  rfe_picker #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_REC(MAX_REC),
    .REC_W(REC_W), .CNT_W(CNT_W)
  ) u_picker (
    .base(baseR), .recSize(sizeR), .recCount(countR), .doneMap(doneMap),
    .availMap(availMap), .pickAny(pickAny), .pickRec(pickRec), .pickAddr(pickAddr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR   <= '0;
      sizeR   <= '0;
      countR  <= '0;
      doneMap <= '0;
      curRec  <= '0;
      wordIdx <= '0;
      curAddr <= '0;
      dataR   <= '0;
    end else begin
      if (stb.loadReq) begin
        baseR   <= reqBase;
        sizeR   <= reqSize;
        countR  <= reqCount;
        doneMap <= '0;
      end
      if (stb.startRec) begin
        curRec  <= pickRec;
        wordIdx <= '0;
        curAddr <= pickAddr;
      end
      if (stb.captWord) dataR <= memRdData;
      if (stb.nextWord) begin
        wordIdx <= wordIdx + SIZE_W'(1);
        curAddr <= curAddr + ADDR_W'(1);
      end
      if (stb.closeRec) doneMap[curRec] <= 1'b1;
    end
  end

  assign wordAvail = availMap[curAddr];
  assign lastWord  = (wordIdx == sizeR - SIZE_W'(1));
  assign memAddr   = curAddr;
  assign outData   = dataR;
  assign outRec    = curRec;
  assign outWord   = wordIdx;

endmodule

// File: rtl/rfe_control.sv
module rfe_control
  import rfe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       outReady,
  input  logic       pickAny,
  input  logic       wordAvail,
  input  logic       lastWord,
  output rfeStrobe_t stb,
  output logic       reqReady,
  output logic       memRdEn,
  output logic       outValid,
  output logic       done
);

  rfeState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_PICK;
      ST_PICK: stateNext = pickAny ? ST_READ : ST_FIN;
      ST_READ: if (wordAvail) stateNext = ST_CAPT;
      ST_CAPT: stateNext = ST_SEND;
      ST_SEND: if (outReady) stateNext = lastWord ? ST_PICK : ST_READ;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb          = '0;
    stb.loadReq  = (state == ST_IDLE) && reqValid;
    stb.startRec = (state == ST_PICK) && pickAny;
    stb.captWord = (state == ST_CAPT);
    stb.nextWord = (state == ST_SEND) && outReady && !lastWord;
    stb.closeRec = (state == ST_SEND) && outReady && lastWord;
  end

  assign reqReady = (state == ST_IDLE);
  assign memRdEn  = (state == ST_READ) && wordAvail;
  assign outValid = (state == ST_SEND);
  assign done     = (state == ST_FIN);

endmodule

// File: rtl/rec_fetch_engine.sv
module rec_fetch_engine
  import rfe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6,
  parameter int SIZE_W  = 4,
  parameter int MAX_REC = 16,
  localparam int REC_W  = $clog2(MAX_REC),
  localparam int CNT_W  = $clog2(MAX_REC + 1),
  localparam int MEM_WORDS = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqBase,
  input  logic [SIZE_W-1:0]    reqSize,
  input  logic [CNT_W-1:0]     reqCount,
  input  logic [MEM_WORDS-1:0] availMap,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memRdEn,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [DATA_W-1:0]    outData,
  output logic [REC_W-1:0]     outRec,
  output logic [SIZE_W-1:0]    outWord,
  output logic                 outLast,
  output logic                 done
);

  rfeStrobe_t stb;
  logic pickAny;
  logic wordAvail;
  logic lastWord;

  rfe_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .outReady(outReady),
    .pickAny(pickAny), .wordAvail(wordAvail), .lastWord(lastWord),
    .stb(stb), .reqReady(reqReady), .memRdEn(memRdEn),
    .outValid(outValid), .done(done)
  );

  rfe_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .MAX_REC(MAX_REC), .REC_W(REC_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqBase(reqBase), .reqSize(reqSize), .reqCount(reqCount),
    .availMap(availMap), .memRdData(memRdData),
    .pickAny(pickAny), .wordAvail(wordAvail), .lastWord(lastWord),
    .memAddr(memAddr), .outData(outData), .outRec(outRec), .outWord(outWord)
  );

  assign outLast = lastWord;

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int SIZE_W    = 4,
  parameter int REC_W     = 4,
  parameter int MEM_WORDS = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [MEM_WORDS-1:0] availMap,
  input logic [ADDR_W-1:0]    memAddr,
  input logic                 memRdEn,
  input logic                 outValid,
  input logic                 outReady,
  input logic [DATA_W-1:0]    outData,
  input logic [REC_W-1:0]     outRec,
  input logic [SIZE_W-1:0]    outWord,
  input logic                 outLast,
  input logic                 done
);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outRec)
                              && $stable(outWord) && $stable(outLast));

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R8
  avail_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> availMap[memAddr]);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && reqReady);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid && !reqReady);

  // R6
  rec_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid);

endmodule

bind rec_fetch_engine rfe_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
  .REC_W(REC_W), .MEM_WORDS(MEM_WORDS)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .availMap(availMap), .memAddr(memAddr), .memRdEn(memRdEn),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outRec(outRec), .outWord(outWord), .outLast(outLast), .done(done)
);

// File: tb/rec_fetch_engine_test.sv
module rec_fetch_engine_test;

  typedef struct packed {
    logic [5:0]  base;
    logic [3:0]  size;
    logic [4:0]  count;
    logic [4:0]  nRec;
    logic [63:0] avail;
    logic [63:0] order;   // nibble k = k-th record expected
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{6'd0,  4'd2, 5'd4,  5'd4,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_3210},
    '{6'd4,  4'd3, 5'd4,  5'd4,  64'hFFFF_FFFF_FFFF_FFEF, 64'h0000_0000_0000_0321},
    '{6'd10, 4'd2, 5'd5,  5'd5,  64'h0000_0000_000C_C000, 64'h0000_0000_0003_1042},
    '{6'd60, 4'd3, 5'd3,  5'd3,  64'hEFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0021},
    '{6'd0,  4'd1, 5'd20, 5'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFEDC_BA98_7654_3210}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic        reqReady;
  logic [5:0]  reqBase = '0;
  logic [3:0]  reqSize = '0;
  logic [4:0]  reqCount = '0;
  logic [63:0] availMap = '0;
  logic [5:0]  memAddr;
  logic        memRdEn;
  logic [15:0] memRdData = '0;
  logic        outValid;
  logic        outReady = 0;
  logic [15:0] outData;
  logic [3:0]  outRec;
  logic [3:0]  outWord;
  logic        outLast;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  rec_fetch_engine uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBase(reqBase), .reqSize(reqSize), .reqCount(reqCount),
    .availMap(availMap), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outRec(outRec), .outWord(outWord),
    .outLast(outLast), .done(done)
  );

  function automatic logic [15:0] memWord(input logic [5:0] a);
    return 16'hB000 + 16'(a) * 16'd5;
  endfunction

  // synchronous memory, one cycle latency
  always @(posedge clk) if (memRdEn) memRdData <= memWord(memAddr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v);
    int slot = 0;
    int expW = 0;
    int beats = 0;
    int phase = 0;
    int slowCnt = 0;
    logic [5:0] slowAddr = '0;
    bit prevStall = 0;
    bit seenDone = 0;
    logic [15:0] pData = '0;
    logic [3:0] pRec = '0, pWord = '0;
    logic pLast = 0;
    @(negedge clk);
    availMap = v.avail;
    reqBase = v.base; reqSize = v.size; reqCount = v.count;
    reqValid = 1;
    outReady = 0;
    @(negedge clk);
    check(reqReady == 0, "R2", "busy after accept", reqReady, 0);
    reqBase = 6'd33; reqSize = 4'd7; reqCount = 5'd9;   // ignored while busy
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (prevStall) begin
        check(outValid && outData == pData && outRec == pRec &&
              outWord == pWord && outLast == pLast, "R7", "stall hold",
              {outValid, outRec, outWord, outData}, {1'b1, pRec, pWord, pData});
      end
      if (memRdEn) check(availMap[memAddr], "R8", "read of unavailable word", memAddr, 0);
      // slow path: an unavailable word under the read address fills after 5 cycles
      if (!availMap[memAddr] && !reqReady) begin
        if (memAddr == slowAddr) slowCnt++;
        else begin slowAddr = memAddr; slowCnt = 1; end
        if (slowCnt >= 5) availMap[memAddr] = 1'b1;
      end
      outReady = (phase % 4) != 2;
      phase++;
      if (outValid && outReady) begin
        beats++;
        if (slot >= int'(v.nRec)) begin
          check(0, "R9", "extra beat", slot, v.nRec);
        end else begin
          int r = int'(v.order[slot*4 +: 4]);
          logic [5:0] a = 6'(int'(v.base) + r * int'(v.size) + expW);
          check(outRec == 4'(r), "R3 R4", "record order", outRec, r);
          check(outWord == 4'(expW), "R6", "word index", outWord, expW);
          check(outLast == (expW == int'(v.size) - 1), "R6", "last flag", outLast,
                expW == int'(v.size) - 1);
          check(outData == memWord(a), "R5 R12", "data word", outData, memWord(a));
          if (expW == int'(v.size) - 1) begin slot++; expW = 0; end
          else expW++;
        end
      end
      prevStall = outValid && !outReady;
      pData = outData; pRec = outRec; pWord = outWord; pLast = outLast;
      if (done) begin
        seenDone = 1;
        reqValid = 0;
        check(slot == int'(v.nRec) && expW == 0, "R9", "records before done", slot, v.nRec);
        break;
      end
    end
    check(seenDone, "R9", "done raised", seenDone, 1);
    check(beats == int'(v.nRec) * int'(v.size), "R5", "beat total", beats,
          int'(v.nRec) * int'(v.size));
    reqValid = 0;
    outReady = 0;
    @(negedge clk);
    check(reqReady && !done, "R9", "idle after done", {reqReady, done}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady == 1, "R1", "reqReady", reqReady, 1);
    check(outValid == 0 && done == 0 && memRdEn == 0, "R1", "outputs idle",
          {outValid, done, memRdEn}, 0);
    rstN = 1;
    @(negedge clk);
    check(reqReady == 1 && outValid == 0, "R1", "idle after reset",
          {reqReady, outValid}, 2'b10);

    for (int i = 0; i < NVEC; i++) runVec(VEC[i]);   // R3 R4 R5 R6 R11 in table

    // R10 zero count and zero size
    runVec('{6'd5, 4'd2, 5'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0});
    runVec('{6'd5, 4'd0, 5'd3, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0});
    // R4 nothing available at all: pure index order with waiting
    runVec('{6'd20, 4'd2, 5'd3, 5'd3, 64'h0, 64'h210});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule